// File: doc/BRIEF.md
# Bus Error Capture Registers

This unit sits next to a memory or bus controller and keeps a record of the first bus error that the controller reports, so that software can read it later. Each error event comes in as a one-cycle strobe with its attributes: whether it was an ECC error, whether the CPU or a DMA agent issued the cycle, whether it was a write, the failing word address, and for ECC errors a per-bank check result. The unit packs these into two 32-bit registers: an error-address register and a check/syndrome register with one 16-bit half for each of two memory banks.

While a record is held, the interrupt output is high and later errors leave the record untouched; a separate overflow output shows that at least one later error was dropped. Software reads the registers through a small register port. Any write to the error-address register clears the record, the overflow flag and the interrupt, and no write data is needed for this. For ECC errors on read cycles, the memory pipeline reports the failing word five words late. The unit therefore records the word address with its low 12 bits advanced by five, wrapping inside the 4 KiB window, so software can take that offset back out. Detecting errors and computing ECC are done elsewhere.

Top module: `buserr_capture`

## Requirements
- R1: After reset, `irq` and `ovf` are 0 and both registers read as 0.
- R2: A strobe while no record is held loads the error-address register. Bit 31 is valid (1), bit 30 is the CPU agent (0 means DMA), bit 29 is write, bit 28 is ECC error and bits 27:0 hold the word address. `irq` rises in the same clock edge.
- R3: A strobe while a record is held, with no clearing write in that cycle, changes neither register and sets `ovf` to 1.
- R4: A write with `reg_addr` = 0 (error-address register) clears both registers, `irq` and `ovf` at the next clock edge.
- R5: A write with `reg_addr` = 1 (syndrome register) changes no register and no output.
- R6: For an ECC error on a read (ECC = 1, write = 0), bits 11:0 of the recorded address equal the input's bits 11:0 plus 5, taken modulo 4096. Bits 27:12 are copied unchanged.
- R7: For an ECC error on a write, and for every non-ECC error, the recorded address equals the input word address.
- R8: For an ECC error, the syndrome register holds bank 0 in bits 15:0 and bank 1 in bits 31:16. Within each half, bit 15 is that bank's valid flag, bit 8 its single-bit flag, bits 6:0 its syndrome, and the other bits are 0.
- R9: For a non-ECC error (CPU timeout or DMA overrun), the syndrome register reads 0.
- R10: A clearing write and a strobe in the same cycle leave the new error recorded, with `irq` at 1 and `ovf` at 0.
- R11: `reg_rdata` shows the error-address register when `reg_addr` = 0 and the syndrome register when `reg_addr` = 1, without delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| err_strobe | input | 1 | One-cycle error event |
| err_ecc | input | 1 | Event is an ECC error |
| err_cpu | input | 1 | Agent is the CPU (0: DMA) |
| err_write | input | 1 | Failing cycle was a write |
| err_waddr | input | 28 | Failing word address |
| err_bank_vld | input | 2 | Per-bank check result valid |
| err_bank_sngl | input | 2 | Per-bank single-bit error flag |
| err_bank_syn | input | 14 | Per-bank 7-bit syndromes, bank 0 in bits 6:0 |
| reg_addr | input | 1 | Register select: 0 error address, 1 syndrome |
| reg_wen | input | 1 | Register write strobe |
| reg_rdata | output | 32 | Selected register contents |
| irq | output | 1 | High while a record is held |
| ovf | output | 1 | A later error was dropped |

## Verification
An error strobe or a clearing write that is sampled at a rising edge shows up in both registers, `irq` and `ovf` straight after that edge. The read mux follows `reg_addr` without any cycle of delay. The bench therefore drives every input at a falling edge and lets exactly one rising edge pass. It then samples at the next falling edge, and for each register it changes `reg_addr` and waits a short delay before it compares. Because of this, each result is checked exactly one edge after the stimulus that caused it.

// File: rtl/buserr_pkg.sv
// Package: shared field positions and the bank-half layout of the
// bus error capture unit. Assumes a 32-bit register port.
package buserr_pkg;
    localparam int REG_W      = 32;
    localparam int EAR_VLD    = 31;
    localparam int EAR_CPU    = 30;
    localparam int EAR_WR     = 29;
    localparam int EAR_ECC    = 28;
    localparam int EAR_FLD_W  = 28;
    localparam int NBANK      = 2;
    localparam int HALF_W     = REG_W / NBANK;
    localparam int HALF_VLD   = 15;
    localparam int HALF_SNGL  = 8;
    localparam int SYN_W      = 7;

    // Attributes of one error event
    typedef struct packed {
        logic ecc;
        logic cpu;
        logic write;
    } err_kind_t;

    // Builds one 16-bit bank half from its valid, single and syndrome fields
    function automatic logic [HALF_W-1:0] pack_half(input logic v,
                                                    input logic s,
                                                    input logic [SYN_W-1:0] syn);
        logic [HALF_W-1:0] h;
        h = '0;
        h[HALF_VLD]    = v;
        h[HALF_SNGL]   = s;
        h[SYN_W-1:0]   = syn;
        return h;
    endfunction
endpackage

// File: rtl/buserr_addr_adj.sv
// Address adjust: for ECC errors on reads, advances the low WIN_W bits
// of the word address by RD_OFS and wraps inside the window. All other
// events pass the address through. Assumes ADDR_W > WIN_W.
module buserr_addr_adj #(
    parameter int ADDR_W = 28,
    parameter int WIN_W  = 12,
    parameter int RD_OFS = 5
) (
    input  logic [ADDR_W-1:0] waddr,
    input  logic              ecc,
    input  logic              write,
    output logic [ADDR_W-1:0] adj
);
    logic [WIN_W-1:0] low_sum;

    // Wrapping sum of the window offset bits
    always_comb low_sum = waddr[WIN_W-1:0] + WIN_W'(RD_OFS);

    // Select the adjusted form only for ECC read events
    always_comb begin
        if (ecc && !write)
            adj = {waddr[ADDR_W-1:WIN_W], low_sum};
        else
            adj = waddr;
    end
endmodule

// File: rtl/buserr_syn_pack.sv
// Syndrome packer: builds the syndrome word from per-bank check
// results, one 16-bit half per bank, with bank 0 in the low half.
module buserr_syn_pack
    import buserr_pkg::*;
#(
    parameter int NB = NBANK
) (
    input  logic [NB-1:0]        vld,
    input  logic [NB-1:0]        sngl,
    input  logic [NB*SYN_W-1:0]  syn,
    output logic [NB*HALF_W-1:0] word
);
    for (genvar b = 0; b < NB; b++) begin : g_bank
        // One half per bank, laid out by the package helper
        assign word[b*HALF_W +: HALF_W] = pack_half(vld[b], sngl[b], syn[b*SYN_W +: SYN_W]);
    end
endmodule

// File: rtl/buserr_record.sv
// Record holder: keeps the first error until it is cleared. A clear and
// a new event in the same cycle leave the new event recorded. Later
// events while a record is held only set the overflow flag.
module buserr_record
    import buserr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             strobe,
    input  logic             clear,
    input  logic [REG_W-1:0] ear_in,
    input  logic [REG_W-1:0] syn_in,
    output logic [REG_W-1:0] ear_q,
    output logic [REG_W-1:0] syn_q,
    output logic             ovf_q
);
    logic held;

    // A record is held while the stored valid flag is set
    always_comb held = ear_q[EAR_VLD];

    // Capture, clear and overflow update of the stored record
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ear_q <= '0;
            syn_q <= '0;
            ovf_q <= 1'b0;
        end else if (strobe && (clear || !held)) begin
            ear_q <= ear_in;
            syn_q <= syn_in;
            ovf_q <= 1'b0;
        end else if (clear) begin
            ear_q <= '0;
            syn_q <= '0;
            ovf_q <= 1'b0;
        end else if (strobe) begin
            ovf_q <= 1'b1;
        end
    end
endmodule

// File: rtl/buserr_capture.sv
// Top of the bus error capture unit: forms the address and syndrome
// words from an event, hands them to the record holder, and decodes
// the register port. Assumes ADDR_W <= 28 so that the field fits.
module buserr_capture
    import buserr_pkg::*;
#(
    parameter int ADDR_W = 28,
    parameter int WIN_W  = 12,
    parameter int RD_OFS = 5
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    err_strobe,
    input  logic                    err_ecc,
    input  logic                    err_cpu,
    input  logic                    err_write,
    input  logic [ADDR_W-1:0]       err_waddr,
    input  logic [NBANK-1:0]        err_bank_vld,
    input  logic [NBANK-1:0]        err_bank_sngl,
    input  logic [NBANK*SYN_W-1:0]  err_bank_syn,
    input  logic                    reg_addr,
    input  logic                    reg_wen,
    output logic [REG_W-1:0]        reg_rdata,
    output logic                    irq,
    output logic                    ovf
);
    localparam logic SEL_EAR = 1'b0;

    err_kind_t          kind;
    logic [ADDR_W-1:0]  adj_addr;
    logic [REG_W-1:0]   syn_word;
    logic [REG_W-1:0]   ear_in;
    logic [REG_W-1:0]   syn_in;
    logic [REG_W-1:0]   ear_q;
    logic [REG_W-1:0]   syn_q;
    logic               clear;

    // Gather event attributes
    always_comb kind = '{ecc: err_ecc, cpu: err_cpu, write: err_write};

    buserr_addr_adj #(
        .ADDR_W (ADDR_W),
        .WIN_W  (WIN_W),
        .RD_OFS (RD_OFS)
    ) u_adj (
        .waddr (err_waddr),
        .ecc   (kind.ecc),
        .write (kind.write),
        .adj   (adj_addr)
    );

    buserr_syn_pack #(
        .NB (NBANK)
    ) u_pack (
        .vld  (err_bank_vld),
        .sngl (err_bank_sngl),
        .syn  (err_bank_syn),
        .word (syn_word)
    );

    // Assemble the address word with its status flags
    always_comb begin
        ear_in                   = '0;
        ear_in[EAR_VLD]          = 1'b1;
        ear_in[EAR_CPU]          = kind.cpu;
        ear_in[EAR_WR]           = kind.write;
        ear_in[EAR_ECC]          = kind.ecc;
        ear_in[ADDR_W-1:0]       = adj_addr;
    end

    // Syndrome word only carries data for ECC events
    always_comb syn_in = kind.ecc ? syn_word : '0;

    // Any write to the address register clears the record
    always_comb clear = reg_wen && (reg_addr == SEL_EAR);

    buserr_record u_rec (
        .clk    (clk),
        .rst_n  (rst_n),
        .strobe (err_strobe),
        .clear  (clear),
        .ear_in (ear_in),
        .syn_in (syn_in),
        .ear_q  (ear_q),
        .syn_q  (syn_q),
        .ovf_q  (ovf)
    );

    // Read mux and interrupt
    always_comb reg_rdata = (reg_addr == SEL_EAR) ? ear_q : syn_q;
    always_comb irq = ear_q[EAR_VLD];
endmodule

// File: rtl/buserr_capture_chk.sv
// Checker for the bus error capture unit, bound to the top module.
module buserr_capture_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        err_strobe,
    input logic        err_ecc,
    input logic        reg_addr,
    input logic        reg_wen,
    input logic        irq,
    input logic        ovf,
    input logic [31:0] ear_q,
    input logic [31:0] syn_q
);
    logic clr;
    always_comb clr = reg_wen && !reg_addr;

    // R2: an event with no record held raises the interrupt
    p_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (err_strobe && !irq) |=> irq);

    // R3: later events leave the record alone and flag overflow
    p_first_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (err_strobe && irq && !clr) |=> ($stable(ear_q) && $stable(syn_q) && ovf));

    // R4: clearing write without a new event empties the record
    p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !err_strobe) |=> (!irq && !ovf && syn_q == 32'h0));

    // R5: writes to the syndrome register change nothing
    p_synwr_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wen && reg_addr && !err_strobe) |=> ($stable(ear_q) && $stable(syn_q) && $stable(ovf)));

    // R9: a captured non-ECC event leaves the syndrome register empty
    p_noecc_syn_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (err_strobe && !err_ecc && (!irq || clr)) |=> (syn_q == 32'h0));

    // R10: clear plus event gives a fresh record with no overflow
    p_clear_and_event_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (err_strobe && clr) |=> (irq && !ovf));
endmodule

bind buserr_capture buserr_capture_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .err_strobe (err_strobe),
    .err_ecc    (err_ecc),
    .reg_addr   (reg_addr),
    .reg_wen    (reg_wen),
    .irq        (irq),
    .ovf        (ovf),
    .ear_q      (ear_q),
    .syn_q      (syn_q)
);

// File: tb/buserr_capture_tb.sv
module buserr_capture_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        err_strobe = 1'b0;
    logic        err_ecc = 1'b0;
    logic        err_cpu = 1'b0;
    logic        err_write = 1'b0;
    logic [27:0] err_waddr = '0;
    logic [1:0]  err_bank_vld = '0;
    logic [1:0]  err_bank_sngl = '0;
    logic [13:0] err_bank_syn = '0;
    logic        reg_addr = 1'b0;
    logic        reg_wen = 1'b0;
    logic [31:0] reg_rdata;
    logic        irq;
    logic        ovf;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    buserr_capture u_dut (
        .clk (clk), .rst_n (rst_n),
        .err_strobe (err_strobe), .err_ecc (err_ecc), .err_cpu (err_cpu),
        .err_write (err_write), .err_waddr (err_waddr),
        .err_bank_vld (err_bank_vld), .err_bank_sngl (err_bank_sngl),
        .err_bank_syn (err_bank_syn),
        .reg_addr (reg_addr), .reg_wen (reg_wen),
        .reg_rdata (reg_rdata), .irq (irq), .ovf (ovf)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_ear(input logic e, input logic c, input logic w,
                                            input logic [27:0] a);
        logic [27:0] f;
        f = a;
        if (e && !w) f[11:0] = 12'((32'(a[11:0]) + 5) % 4096);
        return {1'b1, c, w, e, f};
    endfunction

    function automatic logic [31:0] exp_syn(input logic e, input logic [1:0] v,
                                            input logic [1:0] s, input logic [13:0] y);
        if (!e) return 32'h0;
        return {v[1], 6'b0, s[1], 1'b0, y[13:7], v[0], 6'b0, s[0], 1'b0, y[6:0]};
    endfunction

    // Reads both registers through the port and compares them
    task automatic read_both(input string req, input logic [31:0] ee, input logic [31:0] es);
        reg_addr = 1'b0; #1;
        check(req, reg_rdata, ee);
        reg_addr = 1'b1; #1;
        check(req, reg_rdata, es);
        reg_addr = 1'b0;
    endtask

    task automatic fire(input logic e, input logic c, input logic w, input logic [27:0] a,
                        input logic [1:0] v, input logic [1:0] s, input logic [13:0] y,
                        input logic with_clear);
        @(negedge clk);
        err_ecc = e; err_cpu = c; err_write = w; err_waddr = a;
        err_bank_vld = v; err_bank_sngl = s; err_bank_syn = y;
        err_strobe = 1'b1;
        reg_addr = 1'b0; reg_wen = with_clear;
        @(negedge clk);
        err_strobe = 1'b0; reg_wen = 1'b0;
    endtask

    task automatic reg_write(input logic sel);
        @(negedge clk);
        reg_addr = sel; reg_wen = 1'b1;
        @(negedge clk);
        reg_wen = 1'b0; reg_addr = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        logic [27:0] addrs [8];
        logic [31:0] ee, es;
        addrs[0] = 28'h0000000; addrs[1] = 28'h0000FFA; addrs[2] = 28'h0000FFB;
        addrs[3] = 28'hABCDFFF; addrs[4] = 28'hFFFFFFF; addrs[5] = 28'h1234567;
        addrs[6] = 28'h00007F0; addrs[7] = 28'h5555AAA;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1 irq", {31'b0, irq}, 32'h0);
        check("R1 ovf", {31'b0, ovf}, 32'h0);
        read_both("R1 regs", 32'h0, 32'h0);

        for (int ai = 0; ai < 8; ai++) begin
            for (int k = 0; k < 8; k++) begin
                logic e, c, w;
                logic [1:0] v, s;
                logic [13:0] y;
                int idx;
                idx = ai * 8 + k;
                e = k[2]; c = k[1]; w = k[0];
                v = 2'(idx); s = 2'(idx >> 2) ^ 2'b10;
                y = {7'(idx * 29 + 3), 7'(idx * 13)};
                ee = exp_ear(e, c, w, addrs[ai]);
                es = exp_syn(e, v, s, y);

                // R2 R6 R7 R8 R9 R11: capture and layout
                fire(e, c, w, addrs[ai], v, s, y, 1'b0);
                check("R2 irq", {31'b0, irq}, 32'h1);
                read_both((e && !w) ? "R6 R8 R11 capture" :
                          (e ? "R7 R8 R11 capture" : "R7 R9 R11 capture"), ee, es);

                // R3: a later event is dropped and flagged
                fire(!e, !c, !w, ~addrs[ai], ~v, ~s, ~y, 1'b0);
                read_both("R3 held", ee, es);
                check("R3 ovf", {31'b0, ovf}, 32'h1);

                // R5: write to the syndrome register is ignored
                reg_write(1'b1);
                read_both("R5 ignored", ee, es);
                check("R5 ovf", {31'b0, ovf}, 32'h1);

                // R4: write to the address register clears all
                reg_write(1'b0);
                read_both("R4 cleared", 32'h0, 32'h0);
                check("R4 irq", {31'b0, irq}, 32'h0);
                check("R4 ovf", {31'b0, ovf}, 32'h0);
            end
        end

        // R10: clear and event in the same cycle
        fire(1'b1, 1'b0, 1'b0, 28'h0ABCFFE, 2'b11, 2'b01, 14'h1234, 1'b0);
        fire(1'b0, 1'b1, 1'b1, 28'h0000100, 2'b00, 2'b00, 14'h0, 1'b0);
        check("R10 pre ovf", {31'b0, ovf}, 32'h1);
        fire(1'b0, 1'b1, 1'b0, 28'h7654321, 2'b11, 2'b11, 14'h3FFF, 1'b1);
        read_both("R10 fresh", exp_ear(1'b0, 1'b1, 1'b0, 28'h7654321), 32'h0);
        check("R10 irq", {31'b0, irq}, 32'h1);
        check("R10 ovf", {31'b0, ovf}, 32'h0);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule